// File: doc/BRIEF.md
# DMA Bus Cycle Size Planner

The planner turns one programmed DMA transfer (start address, byte count, block mode, a D16 override and a six-bit address modifier) into an ordered stream of bus cycle descriptors. Each descriptor gives the address, the cycle size, whether it is a block (burst) cycle, and the address modifier to drive. The bus engine downstream takes one descriptor per valid/ready handshake.

When block mode is on, the transfer splits into three parts. Leading single cycles bring the address up to the natural boundary of the burst width. Block cycles then carry the aligned middle. Trailing single cycles finish the bytes that are left. During block cycles the two low modifier bits carry an internal block code. During single cycles they carry the programmed bits. A local address counter is loaded at start and advances by the size of each accepted cycle.

Top module: `dma_cycle_planner`

## Requirements
- R1: After reset `cyc_valid_o` and `done_o` are low and `cyc_addr_o` is zero.
- R2: A `start_i` pulse taken while idle loads the address counter from `start_addr_i`, and the first descriptor is at that address. A `start_i` pulse taken while a transfer is still running is ignored.
- R3: Block mode values 0 and 2 give single cycles only. Each cycle takes the largest size out of 1, 2 and 4 bytes for which the address is aligned and the size does not exceed the remaining count. `cyc_size_o` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R4: Block mode 1 aligns the start to a 4-byte boundary with 1- and 2-byte single cycles. It sends the 4-byte windows that lie fully in range as 4-byte block cycles, then finishes with 2- and 1-byte single cycles.
- R5: Block mode 3 aligns the start to an 8-byte boundary with 1-, 2- and 4-byte single cycles. It sends the full 8-byte windows as 8-byte block cycles, then finishes with 4-, 2- and 1-byte single cycles.
- R6: With `d16_i` set and block mode 1 or 3, the aligned middle goes out as 2-byte block cycles. The leading and trailing parts are the same as without the override.
- R7: A block cycle drives modifier `{am_i[5:2], code}`. The code is parameter `BLK64_AM_LO` for 8-byte bursts and `BLK32_AM_LO` for 4-byte and 2-byte bursts. A single cycle drives the programmed `am_i` unchanged.
- R8: A descriptor stays valid and unchanged until it is accepted. The address counter and remaining count change only on acceptance, and the address advances by the accepted size.
- R9: `done_o` is high for exactly one clock after the last cycle is accepted. A start with a zero count produces no descriptor and raises `done_o` in the next cycle.
- R10: If block mode is on but no full boundary window lies inside the range, every cycle is a single cycle sized as in R3, with the maximum single size of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a transfer when the planner is idle |
| start_addr_i | input | AW | Starting local address |
| byte_cnt_i | input | CW | Transfer length in bytes |
| blk_mode_i | input | 2 | 0/2 off, 1 four-byte bursts, 3 eight-byte bursts |
| d16_i | input | 1 | Use 2-byte bursts instead |
| am_i | input | 6 | Programmed address modifier |
| cyc_ready_i | input | 1 | Downstream accepts the current descriptor |
| cyc_valid_o | output | 1 | Descriptor present |
| cyc_addr_o | output | AW | Local address counter / cycle address |
| cyc_size_o | output | 2 | Cycle size, log2 of bytes |
| cyc_blk_o | output | 1 | Block cycle flag |
| cyc_am_o | output | 6 | Address modifier to drive |
| done_o | output | 1 | One-clock end of transfer pulse |

## Verification
The bench builds the planner with `CW=12` and with `BLK64_AM_LO=2'b00`, which differs from `BLK32_AM_LO=2'b11`. This makes an 8-byte burst code that is swapped with the 4-byte or 2-byte code show up at the modifier output. Start addresses stay below 2^20 so that the address sum never wraps. The 12-bit count gives lengths long enough for head, body and tail in every mode. Random back-pressure on the accept input exercises the hold rules.

// File: rtl/dma_plan_pkg.sv
package dma_plan_pkg;
  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } cyc_size_e;

  function automatic logic [3:0] size_bytes(cyc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/dma_plan_setup.sv
// Splits a new transfer into head (single) and body (block) byte counts.
module dma_plan_setup #(
  parameter int CW = 16
) (
  input  logic [2:0]    addr_lo_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          en_i,
  input  logic          wide_i,
  output logic [CW-1:0] head_o,
  output logic [CW-1:0] body_o
);
  logic [2:0]  mask;
  logic [2:0]  hs;
  logic [CW:0] need;

  always_comb begin
    mask = wide_i ? 3'd7 : 3'd3;
    hs   = (~addr_lo_i + 3'd1) & mask;
    need = {1'b0, CW'(hs)} + (CW+1)'(wide_i ? 8 : 4);
    if (!en_i || ({1'b0, cnt_i} < need)) begin
      head_o = cnt_i;
      body_o = '0;
    end else begin
      head_o = CW'(hs);
      body_o = (cnt_i - CW'(hs)) & ~CW'(mask);
    end
  end
endmodule

// File: rtl/dma_plan_sizer.sv
// Picks the next cycle from current alignment and remaining counts.
module dma_plan_sizer
  import dma_plan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [2:0]    addr_lo_i,
  input  logic [CW-1:0] head_i,
  input  logic [CW-1:0] body_i,
  input  logic [CW-1:0] rem_i,
  input  logic          en_i,
  input  logic          wide_i,
  input  logic          d16_i,
  output cyc_size_e     size_o,
  output logic          blk_o
);
  logic [CW-1:0] limit;
  logic [1:0]    max_nb;
  logic [1:0]    s;

  always_comb begin
    max_nb = (en_i && !wide_i) ? 2'd1 : 2'd2;
    limit  = (head_i != '0) ? head_i : rem_i;
    blk_o  = (head_i == '0) && (body_i != '0);
    s      = 2'd0;
    for (int k = 1; k <= 2; k++) begin
      if ((2'(k) <= max_nb) &&
          ((addr_lo_i & 3'((1 << k) - 1)) == 3'd0) &&
          (limit >= CW'(1 << k)))
        s = 2'(k);
    end
    if (blk_o) size_o = d16_i ? SZ_B2 : (wide_i ? SZ_B8 : SZ_B4);
    else       size_o = cyc_size_e'(s);
  end
endmodule

// File: rtl/dma_plan_am.sv
// Modifier select: block code in bits 1:0 during bursts.
module dma_plan_am #(
  parameter logic [1:0] BLK32_AM_LO = 2'b11,
  parameter logic [1:0] BLK64_AM_LO = 2'b11
) (
  input  logic [5:0] am_i,
  input  logic       blk_i,
  input  logic       burst64_i,
  output logic [5:0] am_o
);
  always_comb begin
    if (blk_i) am_o = {am_i[5:2], burst64_i ? BLK64_AM_LO : BLK32_AM_LO};
    else       am_o = am_i;
  end
endmodule

// File: rtl/dma_cycle_planner.sv
module dma_cycle_planner
  import dma_plan_pkg::*;
#(
  parameter int         AW          = 32,
  parameter int         CW          = 16,
  parameter logic [1:0] BLK32_AM_LO = 2'b11,
  parameter logic [1:0] BLK64_AM_LO = 2'b11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [1:0]    blk_mode_i,
  input  logic          d16_i,
  input  logic [5:0]    am_i,
  input  logic          cyc_ready_i,
  output logic          cyc_valid_o,
  output logic [AW-1:0] cyc_addr_o,
  output logic [1:0]    cyc_size_o,
  output logic          cyc_blk_o,
  output logic [5:0]    cyc_am_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q, head_q, body_q;
  logic          en_q, wide_q, d16_q, done_q;
  logic [5:0]    am_q;

  logic          start_en, start_wide, idle, acc;
  logic [CW-1:0] init_head, init_body;
  cyc_size_e     nxt_size;
  logic          nxt_blk;
  logic [3:0]    nxt_bytes;

  assign start_en   = blk_mode_i[0];
  assign start_wide = blk_mode_i[0] & blk_mode_i[1];
  assign idle       = (rem_q == '0);
  assign acc        = cyc_valid_o & cyc_ready_i;
  assign nxt_bytes  = size_bytes(nxt_size);

  dma_plan_setup #(.CW(CW)) u_setup (
    .addr_lo_i (start_addr_i[2:0]),
    .cnt_i     (byte_cnt_i),
    .en_i      (start_en),
    .wide_i    (start_wide),
    .head_o    (init_head),
    .body_o    (init_body)
  );

  dma_plan_sizer #(.CW(CW)) u_sizer (
    .addr_lo_i (addr_q[2:0]),
    .head_i    (head_q),
    .body_i    (body_q),
    .rem_i     (rem_q),
    .en_i      (en_q),
    .wide_i    (wide_q),
    .d16_i     (d16_q),
    .size_o    (nxt_size),
    .blk_o     (nxt_blk)
  );

  dma_plan_am #(
    .BLK32_AM_LO (BLK32_AM_LO),
    .BLK64_AM_LO (BLK64_AM_LO)
  ) u_am (
    .am_i      (am_q),
    .blk_i     (nxt_blk),
    .burst64_i (wide_q & ~d16_q),
    .am_o      (cyc_am_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      head_q <= '0;
      body_q <= '0;
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      d16_q  <= 1'b0;
      am_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (idle) begin
        if (start_i) begin
          addr_q <= start_addr_i;
          rem_q  <= byte_cnt_i;
          head_q <= init_head;
          body_q <= init_body;
          en_q   <= start_en;
          wide_q <= start_wide;
          d16_q  <= d16_i;
          am_q   <= am_i;
          done_q <= (byte_cnt_i == '0);
        end
      end else if (acc) begin
        addr_q <= addr_q + AW'(nxt_bytes);
        rem_q  <= rem_q - CW'(nxt_bytes);
        if (nxt_blk)              body_q <= body_q - CW'(nxt_bytes);
        else if (head_q != '0)    head_q <= head_q - CW'(nxt_bytes);
        done_q <= (rem_q == CW'(nxt_bytes));
      end
    end
  end

  assign cyc_valid_o = ~idle;
  assign cyc_addr_o  = addr_q;
  assign cyc_size_o  = nxt_size;
  assign cyc_blk_o   = nxt_blk;
  assign done_o      = done_q;

  // R8: descriptor held under back-pressure
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && !cyc_ready_i |=> cyc_valid_o && $stable(cyc_addr_o) &&
      $stable(cyc_size_o) && $stable(cyc_blk_o) && $stable(cyc_am_o));

  // R8: a cycle never runs past the end of the transfer
  p_fit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> CW'(nxt_bytes) <= rem_q);

  // R3: single cycles are naturally aligned
  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && !cyc_blk_o |-> (cyc_addr_o[2:0] & (nxt_bytes[2:0] - 3'd1)) == 3'd0);

  // R4: full-width bursts start on their own boundary
  p_blk_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && cyc_blk_o && !d16_q |->
      (cyc_addr_o[2:0] & (wide_q ? 3'd7 : 3'd3)) == 3'd0);

  // R7: single cycles carry the programmed modifier
  p_am_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o && !cyc_blk_o |-> cyc_am_o == am_q);

  // R9: done never overlaps a live descriptor
  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cyc_valid_o);

  // R2: accepted start loads the counter
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !cyc_valid_o |=> cyc_addr_o == $past(start_addr_i));
endmodule

// File: tb/tb_dma_cycle_planner.sv
module tb_dma_cycle_planner;
  localparam int AW = 32;
  localparam int CW = 12;
  localparam logic [1:0] C32 = 2'b11;
  localparam logic [1:0] C64 = 2'b00;

  typedef struct {
    int    addr;
    int    size;
    bit    blk;
    int    am;
    string tag;
  } desc_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [1:0]    blk_mode = '0;
  logic          d16 = 1'b0;
  logic [5:0]    am = '0;
  logic          ready = 1'b0;
  logic          valid, blk, done;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic [5:0]    am_out;

  int checks = 0;
  int failures = 0;
  desc_t q[$];
  bit exp_done = 0;
  int ready_pct = 75;

  always #2 clk = ~clk;

  dma_cycle_planner #(
    .AW(AW), .CW(CW), .BLK32_AM_LO(C32), .BLK64_AM_LO(C64)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .byte_cnt_i(byte_cnt), .blk_mode_i(blk_mode), .d16_i(d16), .am_i(am),
    .cyc_ready_i(ready), .cyc_valid_o(valid), .cyc_addr_o(addr),
    .cyc_size_o(size), .cyc_blk_o(blk), .cyc_am_o(am_out), .done_o(done)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference: windows fully inside the range are bursts, rest greedy singles.
  function automatic void build(int a, int cnt, int mode, bit w16, int amv);
    int  bw   = (mode == 3) ? 8 : 4;
    bit  en   = (mode == 1) || (mode == 3);
    int  maxs = (mode == 1) ? 2 : 4;
    int  bsz  = w16 ? 2 : bw;
    int  fin  = a + cnt;
    int  hend = ((a + bw - 1) / bw) * bw;
    int  tst  = (fin / bw) * bw;
    bit  body = en && (tst > hend);
    int  code = (mode == 3 && !w16) ? int'(C64) : int'(C32);
    string tag;
    int  p = a;
    if (!en)       tag = "R3";
    else if (!body) tag = "R10";
    else if (w16)  tag = "R6";
    else if (mode == 1) tag = "R4";
    else           tag = "R5";
    while (p < fin) begin
      desc_t d;
      d.addr = p; d.tag = tag;
      if (body && p >= hend && p < tst) begin
        d.size = bsz; d.blk = 1; d.am = (amv & 'h3c) | code;
      end else begin
        int lim = (body && p < hend) ? hend - p : fin - p;
        int s = maxs;
        while (s > 1 && ((p % s) != 0 || s > lim)) s = s / 2;
        d.size = s; d.blk = 0; d.am = amv;
      end
      q.push_back(d);
      p += d.size;
    end
  endfunction

  // Compare outputs at the negedge, then predict the coming posedge.
  task automatic step();
    bit was_idle = (q.size() == 0);
    bit nd = 0;
    ready = ($urandom % 100) < ready_pct;
    chk(done == exp_done, "R9", "done", int'(done), int'(exp_done));
    chk(valid == !was_idle, "R8", "valid", int'(valid), int'(!was_idle));
    if (!was_idle && valid) begin
      chk(int'(addr) == q[0].addr, "R8", "addr", int'(addr), q[0].addr);
      chk((1 << size) == q[0].size, q[0].tag, "size", 1 << size, q[0].size);
      chk(blk == q[0].blk, q[0].tag, "blk", int'(blk), int'(q[0].blk));
      chk(int'(am_out) == q[0].am, "R7", "am", int'(am_out), q[0].am);
    end
    if (!was_idle && ready) begin
      void'(q.pop_front());
      if (q.size() == 0) nd = 1;
    end
    if (start && was_idle) begin
      build(int'(start_addr), int'(byte_cnt), int'(blk_mode), d16, int'(am));
      if (byte_cnt == '0) nd = 1;
    end
    exp_done = nd;
    @(negedge clk);
  endtask

  task automatic run_xfer(int a, int cnt, int mode, bit w16, int amv, bit poke);
    start_addr = AW'(a); byte_cnt = CW'(cnt); blk_mode = 2'(mode);
    d16 = w16; am = 6'(amv); start = 1'b1;
    step();
    start = 1'b0;
    chk(int'(addr) == a, "R2", "start addr", int'(addr), a);
    for (int i = 0; i < 4000 && (q.size() != 0 || exp_done); i++) begin
      // R2: a start while busy must not disturb the running transfer
      if (poke && i == 2) begin
        start_addr = AW'(a + 'h400); byte_cnt = CW'(5); blk_mode = 2'd3; start = 1'b1;
      end else start = 1'b0;
      step();
    end
    start = 1'b0;
    chk(int'(addr) == a + cnt, "R8", "end addr", int'(addr), a + cnt);
    step();
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!valid && !done && addr == '0, "R1", "reset", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !done && addr == '0, "R1", "post reset", int'(valid), 0);

    run_xfer('h1003, 13, 0, 0, 'h0d, 0);   // R3
    run_xfer('h1101, 22, 2, 1, 'h39, 0);   // R3 mode 2 ignores d16
    run_xfer('h2001, 23, 1, 0, 'h0f, 0);   // R4
    run_xfer('h2100, 16, 1, 0, 'h3d, 0);   // R4 aligned
    run_xfer('h3003, 37, 3, 0, 'h0c, 0);   // R5
    run_xfer('h3105, 30, 3, 1, 'h3f, 0);   // R6
    run_xfer('h3202, 19, 1, 1, 'h2b, 0);   // R6
    run_xfer('h4006, 9, 3, 0, 'h09, 0);    // R10
    run_xfer('h4101, 6, 1, 0, 'h09, 0);    // R10
    run_xfer('h5000, 0, 3, 0, 'h0b, 0);    // R9 zero length
    ready_pct = 30;
    run_xfer('h6001, 41, 3, 0, 'h0e, 1);   // R2 busy start, R8 back-pressure
    ready_pct = 100;
    run_xfer('h6101, 27, 1, 0, 'h1f, 0);   // R8 no back-pressure
    ready_pct = 70;
    for (int n = 0; n < 60; n++)
      run_xfer('h8000 + int'($urandom % 'h4000), int'($urandom % 90),
               int'($urandom % 4), 1'($urandom % 2), int'($urandom % 64), 1'($urandom % 2));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule